// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block holds the privileged state that a small 32-bit core changes when it takes an exception and when it leaves one. Each cycle it looks at seven exception requests, the address of the instruction now executing, and that instruction's word. It picks at most one request to take. In a single clock step it then saves the old status word into the saved-status copy that belongs to the target mode. It stores a return address in that mode's link copy, rewrites the mode and mask fields of the status word, and sends the program counter to the fixed vector of that exception.

A return strobe reverses the step, again in one clock. It loads the program counter from the link copy of the mode that is current before the restore, and it reloads the status word from that mode's saved copy. An optional 4-byte correction can be applied to the program counter on return. The 24-bit service number of a software interrupt is taken from the trapping instruction and held for the handler. Software can also write the status word directly, for example to drop into user mode.

The rst_n input is an asynchronous active-low reset. It is expected to be released in step with clk by the reset tree above this block.

Top module: `trap_sequencer`

## Requirements
- R1: While rst_n is low, and in the cycle after an accepted req_rst, the outputs are: status = 0x000000D3 (supervisor mode, both masks set, Thumb bit clear), pc_load = 1 and pc_out = 0x00000000. All saved-status and link copies read as zero, and swi_num = 0.
- R2: Mode codes in status bits [4:0] are: user 0x10, FIQ 0x11, IRQ 0x12, supervisor 0x13, abort 0x17, undefined 0x1B. The mapping from exception to mode is:
  - reset and software interrupt enter supervisor;
  - data abort and prefetch abort enter abort;
  - IRQ enters IRQ, FIQ enters FIQ;
  - undefined instruction enters undefined.
- R3: The vector loaded into pc_out is: reset 0x00, undefined 0x04, software interrupt 0x08, prefetch abort 0x0C, data abort 0x10, IRQ 0x18, FIQ 0x1C.
- R4: On entry, status bit 7 (IRQ mask) is set and bit 5 (Thumb) is cleared. Bit 6 (FIQ mask) is set by FIQ and reset and otherwise keeps its value. Bits [31:8] keep their value.
- R5: On entry, the status word in force before the entry is written into the saved-status copy of the target mode. While that mode is current, the copy is visible on spsr_cur.
- R6: On entry, the target mode's link copy (visible on lr_cur) receives cur_pc + 8 for IRQ, FIQ and data abort, and cur_pc + 4 for the others. For example, an IRQ at 0x30000008 gives 0x30000010.
- R7: req_irq has no effect while status bit 7 is set, and req_fiq has no effect while status bit 6 is set. The next lower request is then considered instead.
- R8: Among the accepted requests, exactly one is taken, in the priority order: reset, data abort, FIQ, IRQ, prefetch abort, undefined, software interrupt.
- R9: exc_ret in a privileged mode sets pc_out to that mode's link copy (minus 4 when ret_sub4 = 1) and status to that mode's saved copy, both in the same cycle, with pc_load = 1.
- R10: exc_ret while the mode field is user (0x10) or any code without a bank does not change status and leaves pc_load at 0.
- R11: When an exception is taken in the same cycle as exc_ret, the entry is performed and the return is discarded. A return or an entry also overrides sr_we in the same cycle.
- R12: On a software interrupt entry, swi_num becomes insn[23:0], with insn[31:24] discarded. No other event except reset changes swi_num.
- R13: With no accepted request and no effective return, sr_we = 1 loads sr_wdata into status with pc_load = 0. lr_cur and spsr_cur always show the copies of the current mode, or zero in user mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_rst | input | 1 | Reset exception request |
| req_dabt | input | 1 | Data abort request |
| req_fiq | input | 1 | Fast interrupt request |
| req_irq | input | 1 | Interrupt request |
| req_pabt | input | 1 | Prefetch abort request |
| req_und | input | 1 | Undefined instruction request |
| req_swi | input | 1 | Software interrupt request |
| exc_ret | input | 1 | Exception return strobe |
| ret_sub4 | input | 1 | Subtract 4 from the link value on return |
| sr_we | input | 1 | Direct status write enable |
| sr_wdata | input | 32 | Direct status write data |
| cur_pc | input | 32 | Address of the executing instruction |
| insn | input | 32 | Word of the executing instruction |
| pc_load | output | 1 | pc_out holds a new target this cycle |
| pc_out | output | 32 | Vector or return target |
| sr | output | 32 | Current status word |
| lr_cur | output | 32 | Link copy of the current mode |
| spsr_cur | output | 32 | Saved-status copy of the current mode |
| swi_num | output | 24 | Last software interrupt number |

## Verification
Two functions can fall in the same cycle: an exception entry and a return. A third, a direct status write, can coincide with either. The bench first walks the block into a handler mode with valid saved state. It then raises the return strobe together with an undefined-instruction request, and separately together with a status write. Every request combination is also swept from user mode under all four mask settings. The bench judges each cycle against its own model of the priority, mask and banking rules: the entry must win over the return, the return must win over the write, and the discarded action must leave no trace on pc_out, the status word or the banked copies.

// File: rtl/trap_pkg.sv
package trap_pkg;

  localparam int NSRC  = 7;
  localparam int NBANK = 5;
  localparam int BIDX_W = $clog2(NBANK);

  localparam logic [4:0] MODE_USR = 5'h10;
  localparam logic [4:0] MODE_FIQ = 5'h11;
  localparam logic [4:0] MODE_IRQ = 5'h12;
  localparam logic [4:0] MODE_SVC = 5'h13;
  localparam logic [4:0] MODE_ABT = 5'h17;
  localparam logic [4:0] MODE_UND = 5'h1B;

  localparam logic [7:0] RESET_SR = 8'hD3;

  // Request order equals priority order, index 0 highest.
  typedef enum logic [2:0] {
    EX_NONE = 3'd0,
    EX_RST  = 3'd1,
    EX_DABT = 3'd2,
    EX_FIQ  = 3'd3,
    EX_IRQ  = 3'd4,
    EX_PABT = 3'd5,
    EX_UND  = 3'd6,
    EX_SWI  = 3'd7
  } exc_e;

  typedef struct packed {
    logic [4:0] mode;
    logic [7:0] vec;
    logic [3:0] lr_off;
    logic       set_f;
  } entry_t;

  function automatic entry_t entry_attr(exc_e k);
    entry_t a;
    a = '{mode: MODE_SVC, vec: 8'h00, lr_off: 4'd4, set_f: 1'b0};
    case (k)
      EX_RST:  a = '{mode: MODE_SVC, vec: 8'h00, lr_off: 4'd4, set_f: 1'b1};
      EX_DABT: a = '{mode: MODE_ABT, vec: 8'h10, lr_off: 4'd8, set_f: 1'b0};
      EX_FIQ:  a = '{mode: MODE_FIQ, vec: 8'h1C, lr_off: 4'd8, set_f: 1'b1};
      EX_IRQ:  a = '{mode: MODE_IRQ, vec: 8'h18, lr_off: 4'd8, set_f: 1'b0};
      EX_PABT: a = '{mode: MODE_ABT, vec: 8'h0C, lr_off: 4'd4, set_f: 1'b0};
      EX_UND:  a = '{mode: MODE_UND, vec: 8'h04, lr_off: 4'd4, set_f: 1'b0};
      EX_SWI:  a = '{mode: MODE_SVC, vec: 8'h08, lr_off: 4'd4, set_f: 1'b0};
      default: a = '{mode: MODE_SVC, vec: 8'h00, lr_off: 4'd4, set_f: 1'b0};
    endcase
    return a;
  endfunction

  // Returns {has_bank, bank_index}.
  function automatic logic [BIDX_W:0] bank_of(logic [4:0] m);
    logic [BIDX_W:0] r;
    case (m)
      MODE_FIQ: r = {1'b1, BIDX_W'(0)};
      MODE_IRQ: r = {1'b1, BIDX_W'(1)};
      MODE_SVC: r = {1'b1, BIDX_W'(2)};
      MODE_ABT: r = {1'b1, BIDX_W'(3)};
      MODE_UND: r = {1'b1, BIDX_W'(4)};
      default:  r = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter
  import trap_pkg::*;
(
  input  logic [NSRC-1:0] req,
  input  logic            irq_mask,
  input  logic            fiq_mask,
  output exc_e            kind
);

  logic [NSRC-1:0] elig;

  always_comb begin
    elig    = req;
    elig[2] = req[2] & ~fiq_mask;
    elig[3] = req[3] & ~irq_mask;
    kind    = EX_NONE;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (elig[i]) kind = exc_e'(3'(i + 1));
    end
  end

endmodule

// File: rtl/trap_bank.sv
module trap_bank #(
  parameter int XLEN  = 32,
  parameter int NBANK = 5,
  localparam int IW   = $clog2(NBANK)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            we,
  input  logic [IW-1:0]   widx,
  input  logic [XLEN-1:0] wlr,
  input  logic [XLEN-1:0] wspsr,
  input  logic [IW-1:0]   ridx,
  output logic [XLEN-1:0] rlr,
  output logic [XLEN-1:0] rspsr
);

  logic [XLEN-1:0] lr_q   [NBANK];
  logic [XLEN-1:0] spsr_q [NBANK];

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    logic en;
    assign en = clr | (we & (widx == IW'(g)));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lr_q[g]   <= '0;
        spsr_q[g] <= '0;
      end else if (en) begin
        lr_q[g]   <= clr ? '0 : wlr;
        spsr_q[g] <= clr ? '0 : wspsr;
      end
    end
  end

  always_comb begin
    rlr   = '0;
    rspsr = '0;
    for (int i = 0; i < NBANK; i++) begin
      if (ridx == IW'(i)) begin
        rlr   = lr_q[i];
        rspsr = spsr_q[i];
      end
    end
  end

endmodule

// File: rtl/trap_sequencer.sv
module trap_sequencer
  import trap_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int SWI_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_rst,
  input  logic             req_dabt,
  input  logic             req_fiq,
  input  logic             req_irq,
  input  logic             req_pabt,
  input  logic             req_und,
  input  logic             req_swi,
  input  logic             exc_ret,
  input  logic             ret_sub4,
  input  logic             sr_we,
  input  logic [XLEN-1:0]  sr_wdata,
  input  logic [XLEN-1:0]  cur_pc,
  input  logic [XLEN-1:0]  insn,
  output logic             pc_load,
  output logic [XLEN-1:0]  pc_out,
  output logic [XLEN-1:0]  sr,
  output logic [XLEN-1:0]  lr_cur,
  output logic [XLEN-1:0]  spsr_cur,
  output logic [SWI_W-1:0] swi_num
);

  localparam logic [XLEN-1:0] SWI_MASK = XLEN'({SWI_W{1'b1}});

  // State registers
  logic [XLEN-1:0]  sr_q, pc_q;
  logic             load_q;
  logic [SWI_W-1:0] swi_q;

  // Next state and enables
  logic [XLEN-1:0]  sr_d, pc_d;
  logic             load_d;
  logic [SWI_W-1:0] swi_d;
  logic             sr_en, pc_en, swi_en;

  // Decode
  exc_e            kind;
  entry_t          attr;
  logic [BIDX_W:0] tgt_b, cur_b;
  logic            ret_ok;

  // Bank ports
  logic              bk_clr, bk_we;
  logic [XLEN-1:0]   bk_lr, rd_lr, rd_spsr;

  trap_arbiter u_arb (
    .req      ({req_swi, req_und, req_pabt, req_irq, req_fiq, req_dabt, req_rst}),
    .irq_mask (sr_q[7]),
    .fiq_mask (sr_q[6]),
    .kind     (kind)
  );

  trap_bank #(.XLEN(XLEN), .NBANK(NBANK)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (bk_clr),
    .we    (bk_we),
    .widx  (tgt_b[BIDX_W-1:0]),
    .wlr   (bk_lr),
    .wspsr (sr_q),
    .ridx  (cur_b[BIDX_W-1:0]),
    .rlr   (rd_lr),
    .rspsr (rd_spsr)
  );

  always_comb begin
    attr   = entry_attr(kind);
    tgt_b  = bank_of(attr.mode);
    cur_b  = bank_of(sr_q[4:0]);
    ret_ok = exc_ret & cur_b[BIDX_W];
    bk_lr  = cur_pc + XLEN'(attr.lr_off);

    sr_d   = sr_q;
    pc_d   = pc_q;
    load_d = 1'b0;
    swi_d  = swi_q;
    sr_en  = 1'b0;
    swi_en = 1'b0;
    bk_clr = 1'b0;
    bk_we  = 1'b0;

    if (kind == EX_RST) begin
      sr_d   = XLEN'(RESET_SR);
      pc_d   = '0;
      load_d = 1'b1;
      swi_d  = '0;
      sr_en  = 1'b1;
      swi_en = 1'b1;
      bk_clr = 1'b1;
    end else if (kind != EX_NONE) begin
      sr_d   = {sr_q[XLEN-1:8], 1'b1, sr_q[6] | attr.set_f, 1'b0, attr.mode};
      pc_d   = XLEN'(attr.vec);
      load_d = 1'b1;
      sr_en  = 1'b1;
      bk_we  = 1'b1;
      if (kind == EX_SWI) begin
        swi_d  = SWI_W'(insn & SWI_MASK);
        swi_en = 1'b1;
      end
    end else if (ret_ok) begin
      sr_d   = rd_spsr;
      pc_d   = rd_lr - XLEN'(ret_sub4 ? 4 : 0);
      load_d = 1'b1;
      sr_en  = 1'b1;
    end else if (sr_we) begin
      sr_d  = sr_wdata;
      sr_en = 1'b1;
    end
    pc_en = load_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= XLEN'(RESET_SR);
      pc_q   <= '0;
      load_q <= 1'b1;
      swi_q  <= '0;
    end else begin
      load_q <= load_d;
      if (sr_en)  sr_q  <= sr_d;
      if (pc_en)  pc_q  <= pc_d;
      if (swi_en) swi_q <= swi_d;
    end
  end

  assign pc_load  = load_q;
  assign pc_out   = pc_q;
  assign sr       = sr_q;
  assign swi_num  = swi_q;
  assign lr_cur   = cur_b[BIDX_W] ? rd_lr   : '0;
  assign spsr_cur = cur_b[BIDX_W] ? rd_spsr : '0;

endmodule

// File: rtl/trap_sequencer_chk.sv
module trap_sequencer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_rst,
  input logic        req_dabt,
  input logic        req_fiq,
  input logic        req_irq,
  input logic        req_pabt,
  input logic        req_und,
  input logic        req_swi,
  input logic        exc_ret,
  input logic        sr_we,
  input logic [31:0] insn,
  input logic        pc_load,
  input logic [31:0] pc_out,
  input logic [31:0] sr,
  input logic [31:0] spsr_cur,
  input logic [23:0] swi_num
);

  logic no_req, banked;
  assign no_req = !(req_rst | req_dabt | req_fiq | req_irq | req_pabt | req_und | req_swi);
  assign banked = sr[4:0] inside {5'h11, 5'h12, 5'h13, 5'h17, 5'h1B};

  a_r4_entry_masks: assert property (@(posedge clk) disable iff (!rst_n)
    (req_rst | req_dabt | req_pabt | req_und | req_swi) |=> (pc_load && sr[7] && !sr[5]));

  a_r7_irq_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (req_irq && sr[7] && !req_rst && !req_dabt && !req_fiq && !req_pabt &&
     !req_und && !req_swi && !exc_ret && !sr_we) |=> (!pc_load && $stable(sr)));

  a_r9_return_restores: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_ret && banked && no_req) |=> (pc_load && sr == $past(spsr_cur)));

  a_r10_user_return_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_ret && sr[4:0] == 5'h10 && no_req && !sr_we) |=> (!pc_load && $stable(sr)));

  a_r11_entry_beats_return: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_ret && req_und && !req_rst && !req_dabt && !req_fiq && !req_irq && !req_pabt)
      |=> (sr[4:0] == 5'h1B && pc_out == 32'h4));

  a_r12_swi_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (req_swi && !req_rst && !req_dabt && !req_fiq && !req_irq && !req_pabt && !req_und)
      |=> (swi_num == $past(insn[23:0])));

endmodule

bind trap_sequencer trap_sequencer_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_rst  (req_rst),
  .req_dabt (req_dabt),
  .req_fiq  (req_fiq),
  .req_irq  (req_irq),
  .req_pabt (req_pabt),
  .req_und  (req_und),
  .req_swi  (req_swi),
  .exc_ret  (exc_ret),
  .sr_we    (sr_we),
  .insn     (insn),
  .pc_load  (pc_load),
  .pc_out   (pc_out),
  .sr       (sr),
  .spsr_cur (spsr_cur),
  .swi_num  (swi_num)
);

// File: tb/test_trap_sequencer.sv
module test_trap_sequencer;

  logic        clk;
  logic        rst_n;
  logic        req_rst, req_dabt, req_fiq, req_irq, req_pabt, req_und, req_swi;
  logic        exc_ret, ret_sub4, sr_we;
  logic [31:0] sr_wdata, cur_pc, insn;
  logic        pc_load;
  logic [31:0] pc_out, sr, lr_cur, spsr_cur;
  logic [23:0] swi_num;

  int n_checks = 0;
  int n_errors = 0;

  // Bench model state
  logic [31:0] m_sr;
  logic [31:0] m_lr   [5];
  logic [31:0] m_spsr [5];
  logic [23:0] m_swi;

  trap_sequencer i_trap_sequencer (
    .clk(clk), .rst_n(rst_n),
    .req_rst(req_rst), .req_dabt(req_dabt), .req_fiq(req_fiq), .req_irq(req_irq),
    .req_pabt(req_pabt), .req_und(req_und), .req_swi(req_swi),
    .exc_ret(exc_ret), .ret_sub4(ret_sub4), .sr_we(sr_we), .sr_wdata(sr_wdata),
    .cur_pc(cur_pc), .insn(insn),
    .pc_load(pc_load), .pc_out(pc_out), .sr(sr), .lr_cur(lr_cur),
    .spsr_cur(spsr_cur), .swi_num(swi_num)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  initial begin
    #(200000 * 20);
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  function automatic int bidx(logic [4:0] m);
    case (m)
      5'h11: return 0;
      5'h12: return 1;
      5'h13: return 2;
      5'h17: return 3;
      5'h1B: return 4;
      default: return -1;
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int i = 0; i < 5; i++) begin
      m_lr[i]   = '0;
      m_spsr[i] = '0;
    end
    m_sr  = 32'h0000_00D3;
    m_swi = '0;
  endtask

  task automatic check_state(input string tag);
    int ci;
    ci = bidx(m_sr[4:0]);
    chk(tag, "sr", sr, m_sr);
    chk(tag, "lr_cur", lr_cur, (ci >= 0) ? m_lr[ci] : 32'h0);
    chk(tag, "spsr_cur", spsr_cur, (ci >= 0) ? m_spsr[ci] : 32'h0);
    chk(tag, "swi_num", {8'h0, swi_num}, {8'h0, m_swi});
  endtask

  // r = {swi, und, pabt, irq, fiq, dabt, rst}
  task automatic step(input logic [6:0] r, input logic ret, input logic s4,
                      input logic we, input logic [31:0] wd, input logic [31:0] pc,
                      input logic [31:0] iw, input string tag);
    int k, ti, ci;
    logic [4:0]  md;
    logic [31:0] vec, off, epc;
    logic        sf, eload;
    @(negedge clk);
    {req_swi, req_und, req_pabt, req_irq, req_fiq, req_dabt, req_rst} = r;
    exc_ret = ret; ret_sub4 = s4; sr_we = we; sr_wdata = wd; cur_pc = pc; insn = iw;

    k = 0;
    if (r[0]) k = 1;
    else if (r[1]) k = 2;
    else if (r[2] && !m_sr[6]) k = 3;
    else if (r[3] && !m_sr[7]) k = 4;
    else if (r[4]) k = 5;
    else if (r[5]) k = 6;
    else if (r[6]) k = 7;
    md = 5'h13; vec = 0; off = 4; sf = 1'b0;
    case (k)
      2: begin md = 5'h17; vec = 32'h10; off = 8; end
      3: begin md = 5'h11; vec = 32'h1C; off = 8; sf = 1'b1; end
      4: begin md = 5'h12; vec = 32'h18; off = 8; end
      5: begin md = 5'h17; vec = 32'h0C; end
      6: begin md = 5'h1B; vec = 32'h04; end
      7: begin md = 5'h13; vec = 32'h08; end
      default: ;
    endcase
    ci = bidx(m_sr[4:0]);
    eload = 1'b0; epc = '0;
    if (k == 1) begin
      clear_model();
      eload = 1'b1;
    end else if (k > 0) begin
      ti = bidx(md);
      m_spsr[ti] = m_sr;
      m_lr[ti]   = pc + off;
      m_sr  = {m_sr[31:8], 1'b1, m_sr[6] | sf, 1'b0, md};
      epc   = vec;
      eload = 1'b1;
      if (k == 7) m_swi = iw[23:0];
    end else if (ret && ci >= 0) begin
      epc   = m_lr[ci] - (s4 ? 32'd4 : 32'd0);
      m_sr  = m_spsr[ci];
      eload = 1'b1;
    end else if (we) begin
      m_sr = wd;
    end

    @(posedge clk);
    #1;
    chk(tag, "pc_load", {31'b0, pc_load}, {31'b0, eload});
    if (eload) chk(tag, "pc_out", pc_out, epc);
    check_state(tag);
  endtask

  task automatic set_user(input logic [1:0] masks, input string tag);
    step(7'b0, 1'b0, 1'b0, 1'b1, {8'hA5, 16'h0, masks, 6'h10}, 32'h0, 32'h0, tag);
  endtask

  initial begin
    rst_n = 1'b0;
    {req_swi, req_und, req_pabt, req_irq, req_fiq, req_dabt, req_rst} = '0;
    exc_ret = 0; ret_sub4 = 0; sr_we = 0; sr_wdata = 0; cur_pc = 0; insn = 0;
    clear_model();
    repeat (2) @(posedge clk);
    #5;
    // R1: state held by the asynchronous reset
    chk("R1", "pc_load", {31'b0, pc_load}, 32'h1);
    chk("R1", "pc_out", pc_out, 32'h0);
    check_state("R1");
    @(negedge clk);
    rst_n = 1'b1;

    // R13: idle cycle then direct status write into user mode
    step(7'b0, 1'b0, 1'b0, 1'b0, 0, 0, 0, "R13");
    set_user(2'b00, "R13");

    // R6 worked example: IRQ at 0x30000008, return with correction
    step(7'b0001000, 1'b0, 1'b0, 1'b0, 0, 32'h3000_0008, 0, "R6");
    chk("R6", "lr_irq", lr_cur, 32'h3000_0010);
    step(7'b0, 1'b1, 1'b1, 1'b0, 0, 0, 0, "R9");
    chk("R9", "resume", pc_out, 32'h3000_000C);

    // R10: return in user mode has no effect
    step(7'b0, 1'b1, 1'b0, 1'b0, 0, 0, 0, "R10");

    // Single request sweep: each source, each mask setting, several addresses
    for (int k = 1; k < 7; k++) begin
      for (int m = 0; m < 4; m++) begin
        for (int p = 0; p < 3; p++) begin
          logic [31:0] pcv;
          pcv = 32'h0000_1000 + 32'(p) * 32'h0F00_0104 + 32'(k << 4);
          set_user(2'(m), "R13");
          step(7'(1 << k), 1'b0, 1'b0, 1'b0, 0, pcv, 32'hEF00_0000 | pcv,
               "R2 R3 R4 R5 R6 R7");
          step(7'b0, 1'b1, 1'(p[0]), 1'b0, 0, 0, 0, "R9 R10");
        end
      end
    end

    // R8: every request combination under every mask setting
    for (int c = 0; c < 128; c++) begin
      for (int m = 0; m < 4; m++) begin
        set_user(2'(m), "R13");
        step(7'(c), 1'b0, 1'b0, 1'b0, 0, 32'h0000_4000 + 32'(c * 4), 32'h1234_5600 + 32'(c),
             "R8 R7 R1");
        step(7'b0, 1'b1, 1'b0, 1'b0, 0, 0, 0, "R9 R10");
      end
    end

    // R11: entry and return in the same cycle
    set_user(2'b00, "R13");
    step(7'b0001000, 1'b0, 1'b0, 1'b0, 0, 32'h0000_8000, 0, "R11");
    step(7'b0100000, 1'b1, 1'b0, 1'b0, 0, 32'h0000_0018, 0, "R11");
    chk("R11", "mode", {27'b0, sr[4:0]}, 32'h1B);
    step(7'b0, 1'b1, 1'b0, 1'b1, 32'h0000_0010, 0, 0, "R11 R9");
    step(7'b0, 1'b1, 1'b0, 1'b0, 0, 0, 0, "R11 R9");
    // status write in a privileged mode followed by return with write
    step(7'b0000010, 1'b0, 1'b0, 1'b0, 0, 32'h0000_9000, 0, "R11");
    step(7'b0, 1'b1, 1'b0, 1'b1, 32'hFFFF_FFFF, 0, 0, "R11 R13");

    // R12: service number capture and hold
    set_user(2'b00, "R13");
    step(7'b1000000, 1'b0, 1'b0, 1'b0, 0, 32'h0000_A000, 32'hEF00_0005, "R12");
    chk("R12", "swi5", {8'h0, swi_num}, 32'h5);
    step(7'b0, 1'b1, 1'b0, 1'b0, 0, 0, 0, "R12");
    step(7'b1000000, 1'b0, 1'b0, 1'b0, 0, 32'h0000_A100, 32'hFFAB_CDEF, "R12");
    chk("R12", "swi_mask", {8'h0, swi_num}, 32'h00AB_CDEF);
    step(7'b0100000, 1'b0, 1'b0, 1'b0, 0, 32'h0000_0008, 32'hEE11_2233, "R12");
    step(7'b0, 1'b1, 1'b0, 1'b0, 0, 0, 0, "R12");

    // R1: reset request clears banks from a busy state
    step(7'b0000001, 1'b1, 1'b0, 1'b1, 32'h0, 32'h0000_B000, 0, "R1");

    @(negedge clk);
    {req_swi, req_und, req_pabt, req_irq, req_fiq, req_dabt, req_rst} = '0;
    exc_ret = 0; sr_we = 0;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule